// File: doc/BRIEF.md
# Packed SIMD Saturating Adder

This block adds two 128-bit operands as a packed vector of independent lanes. An element-size input divides each operand into sixteen 8-bit, eight 16-bit or four 32-bit lanes. An operation code picks how each lane combines its two inputs:

- wrap-around addition
- unsigned clamping addition
- signed clamping addition
- a word-only carry extraction
- an unsigned rounded average
- a signed rounded average

Two further codes move a 32-bit status word into and out of the vector path.

Every lane that clamps during a saturating operation raises a shared saturation event. The event is ORed across lanes into bit 0 of the status word. That bit is sticky: it stays set until software overwrites the status word. Results are registered, and a valid strobe follows each accepted operation by one clock. This makes the unit one stage of an execution pipeline.

Top module: `simd_sat_adder`

## Requirements
- R1: Operation code 0 adds each lane modulo 2^EW. EW is 8, 16 or 32 for elemSize 0, 1 and 2, and elemSize 3 also selects 32. Lane k occupies result bits [k*EW +: EW].
- R2: Operation code 1 adds each lane unsigned. A lane whose true sum exceeds the lane maximum yields all ones.
- R3: Operation code 2 adds each lane as two's-complement. An overflowing lane yields the most positive or the most negative lane value, according to the direction of the overflow.
- R4: Operation code 3 always uses 32-bit lanes and ignores elemSize. Each result word is the carry out of the unsigned 33-bit word sum, in bit 0, with bits 31:1 zero.
- R5: Operation code 4 yields floor((a + b + 1) / 2) per lane, with both lanes taken as unsigned.
- R6: Operation code 5 yields floor((a + b + 1) / 2) per lane, with both lanes taken as signed. The result is the lane-width two's-complement value.
- R7: When any lane of an operation with code 1 or 2 clamps, status bit 0 (satFlag) becomes 1 after that operation. It then stays 1 through later operations other than code 6.
- R8: Operations with codes 0, 3, 4, 5 and 7 never set satFlag, even when their lane sums overflow.
- R9: Operation code 6 loads the 32-bit status word from opB bits [127:96], and its result is all zeros. satFlag then equals bit 96 of that opB.
- R10: Operation code 7 returns the status word in result bits [127:96], with bits [95:0] zero.
- R11: outValid is 1 exactly in the cycle after a cycle with inValid high. result changes only after an accepted operation and holds otherwise.
- R12: While rstN is low, outValid, result and the status word are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation accepted this cycle |
| opCode | input | 3 | Operation selector, codes 0 to 7 |
| elemSize | input | 2 | Lane width: 0 byte, 1 halfword, 2 or 3 word |
| opA | input | 128 | First vector operand |
| opB | input | 128 | Second vector operand, also the source of status writes |
| outValid | output | 1 | Result register updated in the previous cycle |
| result | output | 128 | Registered vector result |
| satFlag | output | 1 | Sticky saturation bit, status bit 0 |

## Verification
The byte lanes are swept exhaustively for every lane mode. Every pair of byte values meets in some lane, which separates modulo wrap from unsigned clamping and from signed clamping at both rails. It also separates the rounding carry of the averages at odd sums. Halfword and word lanes get every pairing of the values zero, one, all ones, most negative and most positive, plus random operands. These expose carries that leak across lane boundaries and wrong sign extension. A scripted status sequence interleaves overflowing non-saturating operations with saturating ones, writes and reads. This shows that the flag is sticky, that it ignores wrap and average overflow, and that only a write clears it.

// File: rtl/psa_pkg.sv
package psa_pkg;

  typedef enum logic [2:0] {
    OP_ADD_WRAP = 3'd0,
    OP_ADD_USAT = 3'd1,
    OP_ADD_SSAT = 3'd2,
    OP_CARRY    = 3'd3,
    OP_AVG_U    = 3'd4,
    OP_AVG_S    = 3'd5,
    OP_STAT_WR  = 3'd6,
    OP_STAT_RD  = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    LM_WRAP,
    LM_USAT,
    LM_SSAT,
    LM_AVGU,
    LM_AVGS
  } lane_mode_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic       load;
    lane_mode_e laneMode;
    logic [1:0] sizeSel;
    logic       carrySel;
    logic       satEn;
    logic       statWr;
    logic       statRd;
  } ctrl_strobe_t;

endpackage

// File: rtl/psa_ctrl.sv
module psa_ctrl
  import psa_pkg::*;
(
  input  logic         inValid,
  input  logic [2:0]   opCode,
  input  logic [1:0]   elemSize,
  output ctrl_strobe_t strb
);

  always_comb begin
    strb          = '0;
    strb.load     = inValid;
    strb.laneMode = LM_WRAP;
    strb.sizeSel  = (elemSize == 2'd3) ? 2'd2 : elemSize;
    unique case (opcode_e'(opCode))
      OP_ADD_WRAP: strb.laneMode = LM_WRAP;
      OP_ADD_USAT: begin strb.laneMode = LM_USAT; strb.satEn = 1'b1; end
      OP_ADD_SSAT: begin strb.laneMode = LM_SSAT; strb.satEn = 1'b1; end
      OP_CARRY:    strb.carrySel = 1'b1;
      OP_AVG_U:    strb.laneMode = LM_AVGU;
      OP_AVG_S:    strb.laneMode = LM_AVGS;
      OP_STAT_WR:  strb.statWr = 1'b1;
      OP_STAT_RD:  strb.statRd = 1'b1;
      default:     strb.laneMode = LM_WRAP;
    endcase
  end

endmodule

// File: rtl/psa_datapath.sv
module psa_datapath
  import psa_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int STAT_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strb,
  input  logic [VEC_W-1:0]   opA,
  input  logic [VEC_W-1:0]   opB,
  output logic               outValid,
  output logic [VEC_W-1:0]   result,
  output logic               satFlag
);

  localparam int NUM_SIZES = 3;
  localparam int WORD_W    = 8 << (NUM_SIZES - 1);
  localparam int NUM_WORDS = VEC_W / WORD_W;

  logic [VEC_W-1:0]     sizeRes [NUM_SIZES];
  logic [NUM_SIZES-1:0] satAny;
  logic [NUM_WORDS-1:0] wordCarry;
  logic [VEC_W-1:0]     carryVec;
  logic [VEC_W-1:0]     selRes;
  logic [VEC_W-1:0]     resNext;
  logic                 selSat;
  logic [STAT_W-1:0]    status;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int EW = 8 << s;
    localparam int NL = VEC_W / EW;
    localparam logic [EW-1:0] POS_MAX = {1'b0, {(EW-1){1'b1}}};
    localparam logic [EW-1:0] NEG_MIN = {1'b1, {(EW-1){1'b0}}};
    logic [VEC_W-1:0] laneRes;
    logic [NL-1:0]    laneSat;

    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [EW-1:0] a, b, uAvg, sAvg, res;
      logic [EW:0]   uSum, sSum;
      logic          sOvf, rnd, sat;

      assign a    = opA[l*EW +: EW];
      assign b    = opB[l*EW +: EW];
      assign uSum = {1'b0, a} + {1'b0, b};
      assign sSum = {a[EW-1], a} + {b[EW-1], b};
      assign sOvf = sSum[EW] ^ sSum[EW-1];
      // (a+b+1)>>1 rebuilt from halved operands: no extra sum bit needed
      assign rnd  = a[0] | b[0];
      assign uAvg = {1'b0, a[EW-1:1]} + {1'b0, b[EW-1:1]} + {{(EW-1){1'b0}}, rnd};
      assign sAvg = {a[EW-1], a[EW-1:1]} + {b[EW-1], b[EW-1:1]} + {{(EW-1){1'b0}}, rnd};

      always_comb begin
        sat = 1'b0;
        unique case (strb.laneMode)
          LM_USAT: begin
            res = uSum[EW] ? {EW{1'b1}} : uSum[EW-1:0];
            sat = uSum[EW];
          end
          LM_SSAT: begin
            res = sOvf ? (sSum[EW] ? NEG_MIN : POS_MAX) : sSum[EW-1:0];
            sat = sOvf;
          end
          LM_AVGU: res = uAvg;
          LM_AVGS: res = sAvg;
          default: res = uSum[EW-1:0];
        endcase
      end

      assign laneRes[l*EW +: EW] = res;
      assign laneSat[l]          = sat;

      if (EW == WORD_W) begin : g_cy
        assign wordCarry[l] = uSum[EW];
      end
    end

    assign sizeRes[s] = laneRes;
    assign satAny[s]  = |laneSat;
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_carry
    assign carryVec[w*WORD_W +: WORD_W] = {{(WORD_W-1){1'b0}}, wordCarry[w]};
  end

  always_comb begin
    unique case (strb.sizeSel)
      2'd0:    begin selRes = sizeRes[0]; selSat = satAny[0]; end
      2'd1:    begin selRes = sizeRes[1]; selSat = satAny[1]; end
      default: begin selRes = sizeRes[2]; selSat = satAny[2]; end
    endcase
    if (strb.statRd)        resNext = {status, {(VEC_W-STAT_W){1'b0}}};
    else if (strb.statWr)   resNext = '0;
    else if (strb.carrySel) resNext = carryVec;
    else                    resNext = selRes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      status   <= '0;
    end else begin
      outValid <= strb.load;
      if (strb.load) begin
        result <= resNext;
        if (strb.statWr)
          status <= opB[VEC_W-1 -: STAT_W];
        else if (strb.satEn && selSat)
          status[0] <= 1'b1;
      end
    end
  end

  assign satFlag = status[0];

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import psa_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int STAT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       opCode,
  input  logic [1:0]       elemSize,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic             outValid,
  output logic [VEC_W-1:0] result,
  output logic             satFlag
);

  ctrl_strobe_t strb;

  psa_ctrl u_ctrl (
    .inValid  (inValid),
    .opCode   (opCode),
    .elemSize (elemSize),
    .strb     (strb)
  );

  psa_datapath #(.VEC_W(VEC_W), .STAT_W(STAT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .result   (result),
    .satFlag  (satFlag)
  );

endmodule

// File: rtl/psa_checker.sv
module psa_checker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [2:0]       opCode,
  input logic             outValid,
  input logic [VEC_W-1:0] result,
  input logic             satFlag
);

  localparam logic [VEC_W-1:0] CARRY_ZMASK = {(VEC_W/32){32'hFFFF_FFFE}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R11
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R11
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result)); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !(inValid && opCode == 3'd6)) |=> satFlag); // R7
  AST_FLAG_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!satFlag && !(inValid && (opCode == 3'd1 || opCode == 3'd2 || opCode == 3'd6)))
      |=> !satFlag); // R8
  AST_CARRY_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd3) |=> ((result & CARRY_ZMASK) == '0)); // R4
  AST_READ_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd7) |=> (result[VEC_W-33:0] == '0)); // R10
  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd6) |=> (result == '0)); // R9

endmodule

bind simd_sat_adder psa_checker #(.VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opCode   (opCode),
  .outValid (outValid),
  .result   (result),
  .satFlag  (satFlag)
);

// File: tb/simd_sat_adder_tb.sv
module simd_sat_adder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [2:0]    opCode = '0;
  logic [1:0]    elemSize = '0;
  logic [VW-1:0] opA = '0;
  logic [VW-1:0] opB = '0;
  logic          outValid;
  logic [VW-1:0] result;
  logic          satFlag;

  int          nChecks = 0;
  int          nFail = 0;
  logic [31:0] expStatus = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sat_adder u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .elemSize(elemSize), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .satFlag(satFlag)
  );

  function automatic string tagOf(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  // arithmetic model of one lane operation over the whole vector
  function automatic void model(input int op, input int sz, input logic [VW-1:0] a,
                                input logic [VW-1:0] b, output logic [VW-1:0] r,
                                output bit sat);
    int ew;
    longint mask, half, ua, ub, sa, sb, s, res;
    ew = (op == 3) ? 32 : (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    mask = (64'sd1 <<< ew) - 1;
    half = 64'sd1 <<< (ew - 1);
    r = '0;
    sat = 0;
    for (int l = 0; l < VW / ew; l++) begin
      ua = longint'((a >> (l * ew)) & VW'(mask));
      ub = longint'((b >> (l * ew)) & VW'(mask));
      sa = (ua >= half) ? ua - (mask + 1) : ua;
      sb = (ub >= half) ? ub - (mask + 1) : ub;
      case (op)
        1: begin s = ua + ub; if (s > mask) begin s = mask; sat = 1; end res = s; end
        2: begin
          s = sa + sb;
          if (s > half - 1) begin s = half - 1; sat = 1; end
          else if (s < -half) begin s = -half; sat = 1; end
          res = s;
        end
        3: res = (ua + ub) / (mask + 1);
        4: res = (ua + ub + 1) / 2;
        5: res = (sa + sb + 1) >>> 1;
        default: res = ua + ub;
      endcase
      r = r | (VW'(res & mask) << (l * ew));
    end
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] gotR, input logic [VW-1:0] expR,
                       input logic gotF, input logic expF, input logic gotV);
    nChecks++;
    if (gotR !== expR || gotF !== expF || gotV !== 1'b1) begin
      nFail++;
      $display("FAIL %s result=%h flag=%b valid=%b expected result=%h flag=%b valid=1",
               tag, gotR, gotF, gotV, expR, expF);
    end
  endtask

  task automatic runOp(input int op, input int sz, input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] expR;
    bit sat;
    if (op < 6) begin
      model(op, sz, a, b, expR, sat);
      if ((op == 1 || op == 2) && sat) expStatus[0] = 1'b1;
    end else if (op == 6) begin
      expR = '0;
      expStatus = b[VW-1 -: 32];
    end else begin
      expR = {expStatus, 96'b0};
    end
    @(negedge clk);
    inValid = 1'b1; opCode = 3'(op); elemSize = 2'(sz); opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    check(tagOf(op), result, expR, satFlag, expStatus[0], outValid);
  endtask

  function automatic logic [VW-1:0] rep(input int ew, input longint v);
    logic [VW-1:0] r = '0;
    for (int l = 0; l < VW / ew; l++) r = r | (VW'(v & ((64'sd1 <<< ew) - 1)) << (l * ew));
    return r;
  endfunction

  function automatic longint corner(input int ew, input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return (64'sd1 <<< ew) - 1;
      3: return 64'sd1 <<< (ew - 1);
      default: return (64'sd1 <<< (ew - 1)) - 1;
    endcase
  endfunction

  function automatic logic [VW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL R11 watchdog: got still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin : main
    logic [VW-1:0] a, b, held;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R12 reset state
    nChecks++;
    if (outValid !== 1'b0 || result !== '0 || satFlag !== 1'b0) begin
      nFail++;
      $display("FAIL R12 valid=%b result=%h flag=%b expected 0/0/0", outValid, result, satFlag);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R1-style byte sweep: every byte pair meets in some lane
    for (int op = 0; op < 6; op++) begin
      if (op == 3) continue;
      for (int i = 0; i < 256; i++) begin
        for (int j = 0; j < 16; j++) begin
          a = rep(8, longint'(i));
          for (int l = 0; l < 16; l++) b[l*8 +: 8] = 8'(j * 16 + l);
          runOp(op, 0, a, b);
        end
      end
    end

    // halfword and word lanes: corner pairs and random operands
    for (int sz = 1; sz < 4; sz++) begin
      for (int op = 0; op < 6; op++) begin
        for (int ka = 0; ka < 5; ka++)
          for (int kb = 0; kb < 5; kb++)
            runOp(op, sz, rep((sz == 1) ? 16 : 32, corner((sz == 1) ? 16 : 32, ka)),
                  rep((sz == 1) ? 16 : 32, corner((sz == 1) ? 16 : 32, kb)));
        for (int n = 0; n < 80; n++) runOp(op, sz, rnd128(), rnd128());
      end
    end

    // R4 carry ignores elemSize
    for (int n = 0; n < 60; n++) runOp(3, n % 2, rnd128(), rnd128());

    // R9/R10 status write and read, R8 non-saturating overflow keeps flag clear
    runOp(6, 0, '0, {32'hDEAD_BEEE, 96'h0});
    runOp(7, 0, '0, '0);
    runOp(0, 0, rep(8, 8'hFF), rep(8, 8'h02));   // R8 wrap overflow
    runOp(4, 2, rep(32, 32'hFFFF_FFFF), rep(32, 32'hFFFF_FFFF)); // R8
    runOp(3, 2, rep(32, 32'hFFFF_FFFF), rep(32, 32'h1));         // R8
    runOp(5, 1, rep(16, 16'h7FFF), rep(16, 16'h7FFF));           // R8
    runOp(7, 0, '0, '0);
    // R7 sticky set and hold
    runOp(1, 0, {8'hFF, 120'h0}, {8'h01, 120'h0});
    runOp(0, 0, '0, '0);
    runOp(2, 1, '0, '0);
    runOp(7, 0, '0, '0);
    runOp(6, 0, '0, {32'h1234_5670, 96'h0});
    runOp(7, 0, '0, '0);
    runOp(2, 2, {32'h8000_0000, 96'h0}, {32'hFFFF_FFFF, 96'h0});
    runOp(6, 0, '0, {32'h0000_0001, 96'h0});
    runOp(7, 0, '0, '0);

    // R11 result holds with no accepted operation
    held = result;
    repeat (3) @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0 || result !== held) begin
      nFail++;
      $display("FAIL R11 valid=%b result=%h expected valid=0 result=%h", outValid, result, held);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule